// File: doc/BRIEF.md
# Lookup-Table Scratch Memory

This block is a small scratch memory built from 16-entry, 1-bit storage cells. Writes take effect on the rising edge of the write clock, and only while the active-high write enable is high. Reads are purely combinational: the primary output always shows the word at the current address with no added latency. While a write is pending, the output therefore still shows the stored value until the clock edge that performs the write.

Two parameters set the size. `DW` (1 to 4) sets the word width, which is the number of cells placed side by side. `AW` (4 to 6) sets the address width, which gives 1, 2 or 4 banks of cells stacked in depth. The settings DW=1/AW=4, DW=4/AW=4, DW=2/AW=5 and DW=1/AW=6 give the 16x1, 16x4, 32x2 and 64x1 layouts. The address bits above bit 3 pick which bank takes the write strobe and which bank drives the output multiplexer. With `DUAL_PORT` set, every cell keeps a mirrored copy that receives the same writes. That copy is read through a second, read-only address, independently of the primary port.

A capture register can hold the primary output. It is clocked by the write clock but loads only on its own enable, which is unrelated to the write enable. All storage, including the capture register, powers up holding the parameter `INIT_WORD` at every location.

Top module: `lut_ram`

## Requirements
- R1: Before any write, every address reads `INIT_WORD` on `rdData` and on `dpData`, and `regData` holds `INIT_WORD`.
- R2: A rising `clk` edge with `wrEn` high stores `wrData` at `addr`. From just after that edge, `rdData` at that address shows the new word.
- R3: A rising edge with `wrEn` low changes no location, whatever `wrData` and `addr` carry.
- R4: `rdData` is a combinational function of `addr` and the stored contents. During a write cycle it shows the old word at `addr` until the edge.
- R5: Address bits `addr[AW-1:4]` select the bank. A write to one bank leaves the location with the same low four address bits in every other bank unchanged.
- R6: Each bit of the word is stored independently, so a write stores the exact bit pattern of `wrData`.
- R7: With `DUAL_PORT=1`, `dpData` shows the stored word at `dpAddr` with no latency, and it equals `rdData` whenever `dpAddr == addr`.
- R8: A write on the primary port does not stall the second port. When `dpAddr` equals the written address, `dpData` shows the old word before the edge and the new word right after it.
- R9: At a rising edge with `regEn` high, `regData` takes the value `rdData` had just before the edge. With `regEn` low, `regData` holds, whatever `wrEn` does.
- R10: When `regEn` and `wrEn` are both high at the same edge, `regData` captures the old word at `addr`, not `wrData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; also clocks the capture register |
| wrEn | input | 1 | Active-high write enable |
| addr | input | AW | Primary read/write address |
| wrData | input | DW | Word to store |
| rdData | output | DW | Combinational word at `addr` |
| dpAddr | input | AW | Read-only address of the second port |
| dpData | output | DW | Combinational word at `dpAddr` (zero when `DUAL_PORT=0`) |
| regEn | input | 1 | Load enable of the capture register |
| regData | output | DW | Capture register output |

## Verification
The bench builds the block with DW=2, AW=5, DUAL_PORT=1 and INIT_WORD=2'b10. Two banks put the bank write-enable decode and the read multiplexer in play, as well as aliasing between addresses 16 apart. A two-bit word shows per-bit independence. A nonzero initial word separates never-written locations from written zeros. The mirrored copy makes the same-address and cross-address behaviour of the second port observable while writes are in progress.

// File: rtl/lut_ram_pkg.sv
package lut_ram_pkg;
  // Geometry of one storage cell.
  localparam int CELL_ABITS = 4;
  localparam int CELL_DEPTH = 1 << CELL_ABITS;
  // Largest supported bank count (address width up to 6).
  localparam int MAX_BANKS  = 4;
  localparam int BANK_SELW  = 2;

  // Strobes from the control part to the datapath.
  typedef struct packed {
    logic [MAX_BANKS-1:0] bankWe;   // one-hot write strobe per bank
    logic [BANK_SELW-1:0] rdBank;   // bank selected for the primary read
    logic [BANK_SELW-1:0] dpBank;   // bank selected for the second-port read
    logic                 regLoad;  // capture register load
  } ramStrobe_t;
endpackage

// File: rtl/lut_ram_cell.sv
module lut_ram_cell
  import lut_ram_pkg::*;
#(
  parameter bit INIT_BIT  = 1'b0,
  parameter bit DUAL_PORT = 1'b1
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic                  din,
  input  logic [CELL_ABITS-1:0] wrRdAddr,
  input  logic [CELL_ABITS-1:0] roAddr,
  output logic                  spo,
  output logic                  dpo
);
  localparam logic [CELL_DEPTH-1:0] INIT_VEC = {CELL_DEPTH{INIT_BIT}};

  logic [CELL_DEPTH-1:0] primaryBits = INIT_VEC;

  always_ff @(posedge clk) begin
    if (we) primaryBits[wrRdAddr] <= din;
  end

  assign spo = primaryBits[wrRdAddr];

  generate
    if (DUAL_PORT) begin : g_mirror
      // The copy takes the same write at the same address.
      logic [CELL_DEPTH-1:0] mirrorBits = INIT_VEC;
      always_ff @(posedge clk) begin
        if (we) mirrorBits[wrRdAddr] <= din;
      end
      assign dpo = mirrorBits[roAddr];
    end else begin : g_single
      logic unusedRo;
      assign unusedRo = ^roAddr;
      assign dpo = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lut_ram_ctrl.sv
module lut_ram_ctrl
  import lut_ram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          wrEn,
  input  logic          regEn,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] dpAddr,
  output ramStrobe_t    strobe
);
  localparam int NB = 1 << (AW - CELL_ABITS);

  logic [BANK_SELW-1:0] wrBank;

  always_comb begin
    wrBank         = BANK_SELW'(addr >> CELL_ABITS);
    strobe.rdBank  = wrBank;
    strobe.dpBank  = BANK_SELW'(dpAddr >> CELL_ABITS);
    strobe.regLoad = regEn;
    for (int b = 0; b < MAX_BANKS; b++) begin
      strobe.bankWe[b] = wrEn && (b < NB) && (wrBank == BANK_SELW'(b));
    end
  end
endmodule

// File: rtl/lut_ram_dpath.sv
module lut_ram_dpath
  import lut_ram_pkg::*;
#(
  parameter int          DW        = 1,
  parameter int          AW        = 6,
  parameter bit          DUAL_PORT = 1'b1,
  parameter logic [DW-1:0] INIT_WORD = '0
) (
  input  logic          clk,
  input  ramStrobe_t    strobe,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] dpAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] dpData,
  output logic [DW-1:0] regData
);
  localparam int NB  = 1 << (AW - CELL_ABITS);
  localparam int BW  = (AW > CELL_ABITS) ? (AW - CELL_ABITS) : 1;
  localparam int NSL = 1 << BW;

  logic [DW-1:0] bankRd [NSL];
  logic [DW-1:0] bankDp [NSL];

  genvar b, i;
  generate
    for (b = 0; b < NSL; b++) begin : g_bank
      if (b < NB) begin : g_live
        for (i = 0; i < DW; i++) begin : g_bit
          lut_ram_cell #(
            .INIT_BIT (INIT_WORD[i]),
            .DUAL_PORT(DUAL_PORT)
          ) u_cell (
            .clk     (clk),
            .we      (strobe.bankWe[b]),
            .din     (wrData[i]),
            .wrRdAddr(addr[CELL_ABITS-1:0]),
            .roAddr  (dpAddr[CELL_ABITS-1:0]),
            .spo     (bankRd[b][i]),
            .dpo     (bankDp[b][i])
          );
        end
      end else begin : g_pad
        assign bankRd[b] = '0;
        assign bankDp[b] = '0;
      end
    end
  endgenerate

  // Depth extension: upper address bits steer the output muxes.
  assign rdData = bankRd[strobe.rdBank[BW-1:0]];
  assign dpData = bankDp[strobe.dpBank[BW-1:0]];

  logic [DW-1:0] capReg = INIT_WORD;
  always_ff @(posedge clk) begin
    if (strobe.regLoad) capReg <= rdData;
  end
  assign regData = capReg;
endmodule

// File: rtl/lut_ram.sv
module lut_ram #(
  parameter int            DW        = 1,
  parameter int            AW        = 6,
  parameter bit            DUAL_PORT = 1'b1,
  parameter logic [DW-1:0] INIT_WORD = '0
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic [AW-1:0] dpAddr,
  output logic [DW-1:0] dpData,
  input  logic          regEn,
  output logic [DW-1:0] regData
);
  lut_ram_pkg::ramStrobe_t strobe;

  lut_ram_ctrl #(.AW(AW)) u_ctrl (
    .wrEn  (wrEn),
    .regEn (regEn),
    .addr  (addr),
    .dpAddr(dpAddr),
    .strobe(strobe)
  );

  lut_ram_dpath #(
    .DW(DW), .AW(AW), .DUAL_PORT(DUAL_PORT), .INIT_WORD(INIT_WORD)
  ) u_dpath (
    .clk    (clk),
    .strobe (strobe),
    .addr   (addr),
    .dpAddr (dpAddr),
    .wrData (wrData),
    .rdData (rdData),
    .dpData (dpData),
    .regData(regData)
  );
endmodule

// File: rtl/lut_ram_chk.sv
module lut_ram_chk #(
  parameter int DW        = 1,
  parameter int AW        = 6,
  parameter bit DUAL_PORT = 1'b1
) (
  input logic          clk,
  input logic          wrEn,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] rdData,
  input logic [AW-1:0] dpAddr,
  input logic [DW-1:0] dpData,
  input logic          regEn,
  input logic [DW-1:0] regData
);
  // No reset exists; properties start after the first edge.
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!primed)
    wrEn |=> ((addr != $past(addr)) || (rdData == $past(wrData))));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!primed)
    !wrEn |=> ((addr != $past(addr)) || (rdData == $past(rdData))));

  assert_reg_load_R9: assert property (@(posedge clk) disable iff (!primed)
    regEn |=> (regData == $past(rdData)));

  assert_reg_hold_R9: assert property (@(posedge clk) disable iff (!primed)
    !regEn |=> $stable(regData));

  generate
    if (DUAL_PORT) begin : g_dp
      assert_ports_agree_R7: assert property (@(posedge clk) disable iff (!primed)
        (dpAddr == addr) |-> (dpData == rdData));

      assert_mirror_write_R8: assert property (@(posedge clk) disable iff (!primed)
        (wrEn && (dpAddr == addr)) |=>
          ((dpAddr != $past(addr)) || (dpData == $past(wrData))));
    end
  endgenerate
endmodule

bind lut_ram lut_ram_chk #(.DW(DW), .AW(AW), .DUAL_PORT(DUAL_PORT)) u_chk (
  .clk(clk), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
  .dpAddr(dpAddr), .dpData(dpData), .regEn(regEn), .regData(regData)
);

// File: tb/lut_ram_tb.sv
module lut_ram_tb;
  localparam int            DW    = 2;
  localparam int            AW    = 5;
  localparam int            DEPTH = 1 << AW;
  localparam logic [DW-1:0] INITW = 2'b10;

  logic          clk = 1'b0;
  logic          wrEn = 1'b0, regEn = 1'b0;
  logic [AW-1:0] addr = '0, dpAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData, dpData, regData;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] expReg;

  always #10 clk = ~clk;

  lut_ram #(.DW(DW), .AW(AW), .DUAL_PORT(1'b1), .INIT_WORD(INITW)) u_dut (
    .clk(clk), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .dpAddr(dpAddr), .dpData(dpData), .regEn(regEn), .regData(regData)
  );

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check before the edge, update the model at
  // the edge, check just after it.
  task automatic step(logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                      logic [AW-1:0] dpa, logic re, string preTag, string postTag);
    @(negedge clk);
    wrEn = we; addr = a; wrData = d; dpAddr = dpa; regEn = re;
    #2;
    check(preTag, "rdData before edge", rdData, model[a]);
    check(preTag, "dpData before edge", dpData, model[dpa]);
    @(posedge clk);
    if (re) expReg = model[a];
    if (we) model[a] = d;
    #2;
    check(postTag, "rdData after edge", rdData, model[a]);
    check(postTag, "dpData after edge", dpData, model[dpa]);
    check("R9", "regData after edge", regData, expReg);
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) model[k] = INITW;
    expReg = INITW;
    void'($urandom(32'h1234_5eed));
    #5;
    check("R1", "regData at power-up", regData, INITW);

    // R1: sweep every address on both ports with no write.
    for (int k = 0; k < DEPTH; k++)
      step(1'b0, AW'(k), 2'b11, AW'(DEPTH - 1 - k), 1'b0, "R1", "R1");

    // R4 / R2 / R8: write with the second port on the same address.
    step(1'b1, 5'd5, 2'b01, 5'd5, 1'b0, "R4", "R2");
    step(1'b1, 5'd5, 2'b00, 5'd5, 1'b0, "R8", "R8");

    // R5: same low bits, different banks.
    step(1'b1, 5'd3,  2'b01, 5'd19, 1'b0, "R5", "R5");
    step(1'b1, 5'd19, 2'b11, 5'd3,  1'b0, "R5", "R5");
    step(1'b0, 5'd3,  2'b00, 5'd19, 1'b0, "R5", "R5");

    // R6: distinct bit patterns at one address.
    step(1'b1, 5'd7, 2'b01, 5'd7, 1'b0, "R6", "R6");
    step(1'b1, 5'd7, 2'b10, 5'd7, 1'b0, "R6", "R6");
    step(1'b1, 5'd7, 2'b11, 5'd0, 1'b0, "R6", "R6");

    // R3: enable low with live data leaves contents alone.
    step(1'b0, 5'd3, 2'b10, 5'd3, 1'b0, "R3", "R3");
    step(1'b0, 5'd3, 2'b11, 5'd3, 1'b0, "R3", "R3");

    // R10: capture and write at the same edge picks the old word.
    step(1'b1, 5'd9, 2'b01, 5'd9, 1'b1, "R10", "R10");
    check("R10", "regData holds old word", regData, INITW);

    // R9: hold with the enable low while writes go on elsewhere.
    step(1'b1, 5'd20, 2'b00, 5'd9, 1'b0, "R9", "R9");
    step(1'b0, 5'd7,  2'b00, 5'd20, 1'b1, "R9", "R9");

    // R7: second port on a different address than a write.
    step(1'b1, 5'd30, 2'b01, 5'd19, 1'b0, "R7", "R7");

    // Mixed random traffic.
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] ra, rd;
      ra = AW'($urandom_range(0, DEPTH - 1));
      rd = ($urandom_range(0, 3) == 0) ? ra : AW'($urandom_range(0, DEPTH - 1));
      step(1'($urandom_range(0, 1)), ra, DW'($urandom_range(0, 3)), rd,
           1'($urandom_range(0, 1)), "R7", "R2");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule